// File: doc/BRIEF.md
# Flash Write-Type Command Sequencer

This block runs one protected flash write-type operation on top of a SPI command engine that does the bit shifting. A start strobe captures the operation: an optional write-enable prefix opcode, the main opcode, the payload length, whether a three-byte address goes out ahead of the payload, whether to wait for the device to finish, and the idle gap between status reads. The sequencer sends the prefix and then reads the flash status register until the write-enable latch shows as set. It then sends the main command and, if asked, reads status again until the device stops reporting a write in progress.

Each status read is a one-byte command. Between reads the engine request stays idle for a set number of cycles, and that gap is never shorter than a floor. Each of the two polling phases gives up after a bounded number of reads. In that case the operation ends with an error flag that stays set until the next start. The operation ends with a one-cycle done pulse whatever the outcome, and the last status byte read is held on an output.

Top module: `flash_wr_seq`

## Requirements
- R1: After reset, done_o, error_o, ce_req_o are 0 and status_o is 8'h00.
- R2: With a nonzero prefix opcode, the first engine request carries that opcode with transmit count 0 and receive count 0.
- R3: With prefix opcode 8'h00, no prefix and no write-enable polls are issued; the first engine request is the main command.
- R4: After the prefix, status polls (opcode 8'h05, transmit count 0, receive count 1) repeat until a returned byte has bit 1 set; the main command follows that poll.
- R5: The main command carries the main opcode, receive count 0 and transmit count equal to payload length + 1, plus 3 more when the address flag is set.
- R6: When the wait flag is set, status polls (opcode 8'h05) follow the main command until a returned byte has bit 0 clear; with the flag clear no poll follows the main command.
- R7: Each polling phase issues at most MAX_POLLS reads; if the last one still fails, error_o is set, and a failed write-enable phase issues no main command.
- R8: Before every status poll, ce_req_o is low for exactly max(gap_i, MIN_GAP) cycles after the preceding acknowledge (gap_i captured at start, MIN_GAP = 16).
- R9: done_o is high for exactly one cycle, the cycle after the operation's final engine acknowledge, in both the success and the error outcome.
- R10: error_o and status_o clear in the cycle after an accepted start; error_o then holds until the next start; status_o holds the last polled byte, or 8'h00 when no poll ran.
- R11: A request stays asserted with stable opcode and counts until the engine acknowledges it.
- R12: A start strobe while an operation is in progress is ignored; after done no further request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| pfx_op_i | input | 8 | Prefix opcode, 0 means no prefix |
| cmd_op_i | input | 8 | Main command opcode |
| wait_cmp_i | input | 1 | Poll for completion after the main command |
| addr_en_i | input | 1 | Main command carries a 3-byte address |
| pay_len_i | input | LEN_W | Payload length code L (L+1 bytes) |
| gap_i | input | GAP_W | Requested idle cycles between polls |
| ce_req_o | output | 1 | Request to the command engine, held until ack |
| ce_op_o | output | 8 | Opcode of the request |
| ce_tx_cnt_o | output | LEN_W+1 | Bytes to transmit after the opcode |
| ce_rx_cnt_o | output | LEN_W+1 | Bytes to receive |
| ce_ack_i | input | 1 | One-cycle completion from the engine |
| ce_rdata_i | input | 8 | Received byte, valid with ce_ack_i |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| error_o | output | 1 | Retry bound exhausted, sticky until next start |
| status_o | output | 8 | Last status byte read |

## Verification
Each acknowledge takes one clock to reach the sequencer's state. The next request follows it at once, or after exactly the computed idle gap when it is a poll. done_o rises in the cycle right after the final acknowledge, and error_o and status_o change on that same edge. The bench's engine model runs on falling edges. It records the cycle of every acknowledge, the run of idle cycles before each poll and the cycle in which done is seen, and compares the two cycle stamps, requiring a difference of one. The clearing of error_o and status_o is checked on the falling edge right after the start edge. Stickiness is checked a few cycles after done.

// File: rtl/fws_pkg.sv
package fws_pkg;
  localparam logic [7:0] RDSR_OP = 8'h05;
  localparam int WEL_BIT = 1;
  localparam int WIP_BIT = 0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PFX, ST_WGAP, ST_WPOLL, ST_MAIN, ST_BGAP, ST_BPOLL
  } seq_st_t;

  // idle gap actually applied before a poll
  function automatic int spaced_gap(int req, int floor_v);
    return (req < floor_v) ? floor_v : req;
  endfunction

  // bytes shifted out after the opcode of the main command
  function automatic int main_tx_bytes(int len, logic with_addr);
    return len + 1 + (with_addr ? 3 : 0);
  endfunction
endpackage

// File: rtl/fws_gap_timer.sv
module fws_gap_timer #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [GAP_W-1:0] val_i,
  output logic             zero_o
);
  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fws_retry_ctr.sv
module fws_retry_ctr #(
  parameter int MAX_POLLS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int PW = $clog2(MAX_POLLS + 1);
  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == PW'(MAX_POLLS - 1));

  // R7: failed reads in one phase never pass the bound
  a_r7_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < PW'(MAX_POLLS));
endmodule

// File: rtl/flash_wr_seq.sv
module flash_wr_seq
  import fws_pkg::*;
#(
  parameter int LEN_W     = 8,
  parameter int GAP_W     = 8,
  parameter int MAX_POLLS = 8,
  parameter int MIN_GAP   = 16,
  localparam int CNT_W    = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [7:0]       pfx_op_i,
  input  logic [7:0]       cmd_op_i,
  input  logic             wait_cmp_i,
  input  logic             addr_en_i,
  input  logic [LEN_W-1:0] pay_len_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             ce_req_o,
  output logic [7:0]       ce_op_o,
  output logic [CNT_W-1:0] ce_tx_cnt_o,
  output logic [CNT_W-1:0] ce_rx_cnt_o,
  input  logic             ce_ack_i,
  input  logic [7:0]       ce_rdata_i,
  output logic             done_o,
  output logic             error_o,
  output logic [7:0]       status_o
);
  seq_st_t          st_q, st_d;
  logic [7:0]       pfx_q, cmd_q, stat_q;
  logic             wait_q, addr_q, done_q, err_q;
  logic [LEN_W-1:0] len_q;
  logic [GAP_W-1:0] gap_q, gap_load_val;
  logic             gap_load, gap_zero, rt_clr, rt_inc, rt_last;
  logic             poll_ok, poll_st, gap_st, finish, fail;

  assign gap_load_val = GAP_W'(spaced_gap(int'(gap_q), MIN_GAP) - 1);
  assign poll_st = (st_q == ST_WPOLL) || (st_q == ST_BPOLL);
  assign gap_st  = (st_q == ST_WGAP)  || (st_q == ST_BGAP);
  assign poll_ok = (st_q == ST_WPOLL) ? ce_rdata_i[WEL_BIT] : !ce_rdata_i[WIP_BIT];

  fws_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .load_i(gap_load), .val_i(gap_load_val), .zero_o(gap_zero));

  fws_retry_ctr #(.MAX_POLLS(MAX_POLLS)) u_rty (
    .clk(clk), .rst_n(rst_n), .clr_i(rt_clr), .inc_i(rt_inc), .last_o(rt_last));

  always_comb begin
    st_d     = st_q;
    gap_load = 1'b0;
    rt_clr   = 1'b0;
    rt_inc   = 1'b0;
    finish   = 1'b0;
    fail     = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = (pfx_op_i != 8'h00) ? ST_PFX : ST_MAIN;
      ST_PFX: if (ce_ack_i) begin
        st_d = ST_WGAP; gap_load = 1'b1; rt_clr = 1'b1;
      end
      ST_MAIN: if (ce_ack_i) begin
        if (wait_q) begin st_d = ST_BGAP; gap_load = 1'b1; rt_clr = 1'b1; end
        else begin st_d = ST_IDLE; finish = 1'b1; end
      end
      ST_WGAP: if (gap_zero) st_d = ST_WPOLL;
      ST_BGAP: if (gap_zero) st_d = ST_BPOLL;
      ST_WPOLL, ST_BPOLL: if (ce_ack_i) begin
        if (poll_ok) begin
          if (st_q == ST_WPOLL) st_d = ST_MAIN;
          else begin st_d = ST_IDLE; finish = 1'b1; end
        end else if (rt_last) begin
          st_d = ST_IDLE; finish = 1'b1; fail = 1'b1;
        end else begin
          st_d = (st_q == ST_WPOLL) ? ST_WGAP : ST_BGAP;
          gap_load = 1'b1; rt_inc = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; pfx_q <= '0; cmd_q <= '0; wait_q <= 1'b0; addr_q <= 1'b0;
      len_q <= '0; gap_q <= '0; done_q <= 1'b0; err_q <= 1'b0; stat_q <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= finish;
      if (st_q == ST_IDLE && start_i) begin
        pfx_q <= pfx_op_i; cmd_q <= cmd_op_i; wait_q <= wait_cmp_i; addr_q <= addr_en_i;
        len_q <= pay_len_i; gap_q <= gap_i; err_q <= 1'b0; stat_q <= '0;
      end
      if (poll_st && ce_ack_i) stat_q <= ce_rdata_i;
      if (fail) err_q <= 1'b1;
    end
  end

  always_comb begin
    ce_req_o    = 1'b0;
    ce_op_o     = 8'h00;
    ce_tx_cnt_o = '0;
    ce_rx_cnt_o = '0;
    unique case (st_q)
      ST_PFX:  begin ce_req_o = 1'b1; ce_op_o = pfx_q; end
      ST_MAIN: begin
        ce_req_o    = 1'b1;
        ce_op_o     = cmd_q;
        ce_tx_cnt_o = CNT_W'(main_tx_bytes(int'(len_q), addr_q));
      end
      ST_WPOLL, ST_BPOLL: begin
        ce_req_o = 1'b1; ce_op_o = RDSR_OP; ce_rx_cnt_o = CNT_W'(1);
      end
      default: ;
    endcase
  end

  assign done_o   = done_q;
  assign error_o  = err_q;
  assign status_o = stat_q;

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    error_o && !start_i |=> error_o);
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ce_req_o && !ce_ack_i |=> ce_req_o && $stable(ce_op_o) && $stable(ce_tx_cnt_o)
                              && $stable(ce_rx_cnt_o));
  a_r8_gap_before_poll: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(poll_st) |-> $past(gap_st) && $past(gap_zero));
  a_r3_skip_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) && start_i && (pfx_op_i == 8'h00) |=>
      ce_req_o && (ce_op_o == $past(cmd_op_i)));
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |-> !ce_req_o);
endmodule

// File: tb/sim_flash_wr_seq.sv
module sim_flash_wr_seq;
  localparam int CLK_PER = 10;
  localparam int LEN_W = 8, GAP_W = 8, MAXP = 8, MING = 16, CNT_W = LEN_W + 1;

  logic clk = 0, rst_n = 0;
  logic start_i = 0, wait_cmp_i = 0, addr_en_i = 0, ce_ack_i = 0;
  logic [7:0] pfx_op_i = 0, cmd_op_i = 0, ce_rdata_i = 0;
  logic [LEN_W-1:0] pay_len_i = 0;
  logic [GAP_W-1:0] gap_i = 0;
  logic ce_req_o, done_o, error_o;
  logic [7:0] ce_op_o, status_o;
  logic [CNT_W-1:0] ce_tx_cnt_o, ce_rx_cnt_o;

  always #(CLK_PER/2) clk = ~clk;

  flash_wr_seq #(.LEN_W(LEN_W), .GAP_W(GAP_W), .MAX_POLLS(MAXP), .MIN_GAP(MING)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pfx_op_i(pfx_op_i), .cmd_op_i(cmd_op_i),
    .wait_cmp_i(wait_cmp_i), .addr_en_i(addr_en_i), .pay_len_i(pay_len_i), .gap_i(gap_i),
    .ce_req_o(ce_req_o), .ce_op_o(ce_op_o), .ce_tx_cnt_o(ce_tx_cnt_o), .ce_rx_cnt_o(ce_rx_cnt_o),
    .ce_ack_i(ce_ack_i), .ce_rdata_i(ce_rdata_i), .done_o(done_o), .error_o(error_o),
    .status_o(status_o));

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int want_gap(int g);
    if (g >= MING) return g;
    return MING;
  endfunction
  function automatic int want_tx(int len, bit a);
    return a ? len + 4 : len + 1;
  endfunction

  // engine model state
  int cyc = 0, k_wel = 0, k_bsy = 0, exp_pfx_op = 0;
  bit pending = 0;
  int cnt = 0, ph = 0, idle_run = 0;
  int n_pfx, n_wel, n_main, n_bsy, n_req, pfx_bad, poll_bad, gap_bad, hold_bad, gap_want;
  int main_op, main_tx, main_rx, first_op, last_ack_cyc, done_cyc, done_cnt;
  logic [7:0] last_rd, cap_op;
  logic [CNT_W-1:0] cap_tx, cap_rx;

  task automatic clear_log();
    n_pfx = 0; n_wel = 0; n_main = 0; n_bsy = 0; n_req = 0; pfx_bad = 0; poll_bad = 0;
    gap_bad = 0; hold_bad = 0; main_op = -1; main_tx = -1; main_rx = -1; first_op = -1;
    last_ack_cyc = -1; done_cyc = -1; last_rd = 8'h00; ph = 0; idle_run = 0;
  endtask

  initial begin clear_log(); done_cnt = 0; end

  always @(negedge clk) begin
    logic [7:0] d;
    cyc++;
    if (done_o) begin done_cnt++; done_cyc = cyc; end
    if (ce_ack_i) begin ce_ack_i = 0; pending = 0; end
    if (pending) begin
      if (!ce_req_o || ce_op_o != cap_op || ce_tx_cnt_o != cap_tx || ce_rx_cnt_o != cap_rx)
        hold_bad++;
      if (cnt == 0) begin
        d = 8'($urandom);
        if (cap_tx == 0 && cap_rx == 1 && ph < 2) d[1] = (n_wel > k_wel);
        if (cap_tx == 0 && cap_rx == 1 && ph == 2) d[0] = (n_bsy <= k_bsy);
        if (cap_rx == 1) last_rd = d;
        ce_rdata_i = d;
        ce_ack_i = 1;
        last_ack_cyc = cyc;
      end else cnt--;
    end else if (ce_req_o) begin
      cap_op = ce_op_o; cap_tx = ce_tx_cnt_o; cap_rx = ce_rx_cnt_o;
      pending = 1; cnt = $urandom_range(0, 3);
      if (n_req == 0) first_op = int'(cap_op);
      n_req++;
      if (ph == 0 && exp_pfx_op != 0) begin
        n_pfx++; ph = 1;
        if (cap_op != 8'(exp_pfx_op) || cap_tx != 0 || cap_rx != 0) pfx_bad++;
      end else if (ph < 2 && !(cap_tx == 0 && cap_rx == 1)) begin
        n_main++; ph = 2;
        main_op = int'(cap_op); main_tx = int'(cap_tx); main_rx = int'(cap_rx);
      end else begin
        if (cap_op != 8'h05) poll_bad++;
        if (idle_run != gap_want) gap_bad++;
        if (ph < 2) n_wel++; else n_bsy++;
      end
      idle_run = 0;
    end else idle_run++;
  end

  task automatic run_op(input int pfx, input int op, input bit w, input bit a, input int len,
                        input int g, input int kw, input int kb, input int mid_start);
    int e_wel, e_bsy, dc0, guard;
    bit wfail, bfail, e_main, e_err;
    logic [7:0] e_stat;
    @(negedge clk); #1;
    clear_log();
    k_wel = kw; k_bsy = kb; exp_pfx_op = pfx; gap_want = want_gap(g);
    pfx_op_i = 8'(pfx); cmd_op_i = 8'(op); wait_cmp_i = w; addr_en_i = a;
    pay_len_i = LEN_W'(len); gap_i = GAP_W'(g);
    dc0 = done_cnt;
    start_i = 1;
    @(negedge clk); #1;
    start_i = 0;
    chk(error_o == 0 && status_o == 0, "R10 clear on start", int'(error_o), 0);
    pfx_op_i = 8'h5A; cmd_op_i = 8'hC3; wait_cmp_i = ~w; pay_len_i = ~pay_len_i; gap_i = 0;
    guard = 0;
    while (done_cnt == dc0 && guard < 20000) begin
      @(negedge clk); #1; guard++;
      if (guard == mid_start) begin
        start_i = 1; @(negedge clk); #1; start_i = 0; guard++;
      end
    end
    chk(guard < 20000, "R9 done seen", guard, 0);
    // expected outcome
    wfail = (pfx != 0) && (kw >= MAXP);
    e_wel = (pfx != 0) ? ((kw + 1 < MAXP) ? kw + 1 : MAXP) : 0;
    e_main = !wfail;
    e_bsy = (e_main && w) ? ((kb + 1 < MAXP) ? kb + 1 : MAXP) : 0;
    bfail = e_main && w && (kb >= MAXP);
    e_err = wfail || bfail;
    e_stat = (e_wel + e_bsy == 0) ? 8'h00 : last_rd;
    chk(first_op == ((pfx != 0) ? pfx : op), "R2/R3 first request", first_op, (pfx != 0) ? pfx : op);
    chk(n_pfx == ((pfx != 0) ? 1 : 0) && pfx_bad == 0, "R2 prefix fields", pfx_bad, 0);
    chk(n_wel == e_wel, "R4 enable polls", n_wel, e_wel);
    chk(n_main == (e_main ? 1 : 0), "R7 main issued", n_main, e_main ? 1 : 0);
    if (e_main) begin
      chk(main_op == op && main_rx == 0, "R5 main opcode", main_op, op);
      chk(main_tx == want_tx(len, a), "R5 main tx count", main_tx, want_tx(len, a));
    end
    chk(n_bsy == e_bsy && poll_bad == 0, "R6 busy polls", n_bsy, e_bsy);
    chk(gap_bad == 0, "R8 poll gap", gap_bad, 0);
    chk(hold_bad == 0, "R11 request hold", hold_bad, 0);
    chk(done_cyc == last_ack_cyc + 1, "R9 done timing", done_cyc - last_ack_cyc, 1);
    chk(error_o == e_err, "R7 error result", int'(error_o), int'(e_err));
    chk(status_o == e_stat, "R10 status byte", int'(status_o), int'(e_stat));
    repeat (6) @(negedge clk);
    #1;
    chk(done_cnt == dc0 + 1, "R9 single done", done_cnt - dc0, 1);
    chk(error_o == e_err, "R10 error sticky", int'(error_o), int'(e_err));
    chk(n_req == (n_pfx + n_wel + n_main + n_bsy) && !ce_req_o, "R12 quiet after done", n_req, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #1;
    chk(done_o == 0 && error_o == 0 && ce_req_o == 0 && status_o == 0, "R1 reset state",
        int'(status_o), 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // directed corners
    run_op(8'h06, 8'h02, 1, 1, 3, 0, 0, 2, 30);        // R12 mid-run start
    run_op(0, 8'h20, 0, 1, 0, 5, 0, 0, 0);              // R3 no prefix, no wait
    run_op(8'h06, 8'hD8, 1, 1, 0, 3, MAXP, 0, 0);       // R7 enable never set
    run_op(8'h06, 8'h02, 1, 0, 255, 20, 1, MAXP + 2, 0);// R7 busy never clears
    run_op(8'h06, 8'h01, 1, 0, 1, 17, MAXP - 1, MAXP - 1, 0); // last-poll success
    run_op(0, 8'h31, 1, 0, 7, 16, 0, 3, 0);             // R6 no prefix with wait
    run_op(8'h06, 8'h02, 0, 1, 15, 40, 2, 0, 0);        // R6 no wait after prefix
    // random mix
    for (int i = 0; i < 20; i++) begin
      int p, o;
      p = ($urandom_range(0, 3) == 0) ? 0 : 8'h06;
      do o = $urandom_range(1, 255); while (o == 8'h05);
      run_op(p, o, 1'($urandom), 1'($urandom), $urandom_range(0, 255), $urandom_range(0, 40),
             $urandom_range(0, MAXP), $urandom_range(0, MAXP), 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule